// File: doc/BRIEF.md
# Dual-Channel UART Bus Decoder with Interrupt Summary Overlay

This block sits between a byte-wide host I/O bus and two 16550-style UART channels on one card. It watches a 16-byte window whose position is set by a base setting, splits that window into two 8-register channel windows, and drives a chip select and a 3-bit register offset to the UART cores. Read data from the selected UART is returned to the host. Outside the window the block stays silent.

The block can borrow the scratch-register slot at offset 7 of every channel window. With the overlay on, a read there returns one byte that carries a pending-interrupt flag per channel. Software can then learn which channels need service with a single read, whichever window it uses. The flags follow the UART interrupt lines directly, so they clear on their own once a channel has been serviced. With the overlay off, offset 7 reaches each UART's own scratch register as usual. The overlay switch is a one-bit register loaded through a configuration strobe. It comes out of reset switched on.

The UART write data bus is wired straight from the host to the cores and does not pass through this block.

Top module: `uart_irq_overlay`

## Requirements
- R1: For an access (read or write strobe) whose address lies in the window, address bit 3 picks the channel (0 = channel A, `cs[0]`; 1 = channel B, `cs[1]`), exactly that one select bit is 1, and `reg_off` equals address bits [2:0].
- R2: An address whose bits above bit 3 differ from `base_sel` asserts no select and gives `rdata` = 0.
- R3: With the overlay on, a read at offset 7 of either channel window asserts no select and returns a status byte: bit 0 = `irq[0]` (channel A pending), bit 1 = `irq[1]` (channel B pending), bits 7..2 = 0.
- R4: The status bits hold no state: a change on `irq` shows in `rdata` in the same cycle, and the byte is 0x00 exactly when no `irq` line is high.
- R5: With the overlay on, a write at offset 7 asserts no select, so neither channel's scratch register changes.
- R6: With the overlay off, reads and writes at offset 7 select that window's channel with `reg_off` = 7, so each channel's scratch register is reached on its own.
- R7: The overlay switch is 1 after reset. On a clock edge with `cfg_we` = 1 it loads `cfg_ovl_en`, and the new value takes effect from that edge on.
- R8: With neither `rd` nor `wr` high, no select is asserted and `rdata` is 0.
- R9: A read at an in-window offset other than the overlaid slot returns the selected channel's byte from `uart_rdata` (channel c at bits [8c+7:8c]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the overlay switch |
| cfg_ovl_en | input | 1 | New overlay switch value |
| base_sel | input | ADDR_W-4 | Address bits above the 16-byte window (base divided by 16) |
| addr | input | ADDR_W | Host I/O address |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| irq | input | NCH | Per-channel interrupt outputs of the UARTs |
| uart_rdata | input | 8*NCH | Read data from each UART, channel c in byte c |
| cs | output | NCH | Per-channel chip selects |
| reg_off | output | 3 | Register offset to the UARTs |
| rdata | output | 8 | Read data to the host |

## Verification
The bench builds the block with an 8-bit address and two channels. With that setting, every host address can be swept against several base settings, every interrupt pattern and both overlay states. Simple scratch-register models stand in for the UARTs. They let the bench confirm that blocked writes leave the cores untouched and that unblocked writes land in the right channel. Expected selects, offsets and read bytes are worked out arithmetically from the address.

// File: rtl/uovl_pkg.sv
package uovl_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned OFF_W     = 3;
  localparam logic [2:0]  STATUS_OFF = 3'd7;
endpackage

// File: rtl/uovl_decode.sv
module uovl_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NCH    = 2,
  localparam int unsigned CH_W    = $clog2(NCH),
  localparam int unsigned WIN_LSB = CH_W + uovl_pkg::OFF_W
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-WIN_LSB-1:0] base_sel,
  output logic                      hit,
  output logic [CH_W-1:0]           ch,
  output logic [uovl_pkg::OFF_W-1:0] off
);
  assign hit = (addr[ADDR_W-1:WIN_LSB] == base_sel);
  assign ch  = addr[WIN_LSB-1:uovl_pkg::OFF_W];
  assign off = addr[uovl_pkg::OFF_W-1:0];
endmodule

// File: rtl/uovl_status.sv
module uovl_status #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0]              irq,
  output logic [uovl_pkg::DATA_W-1:0] status
);
  for (genvar i = 0; i < uovl_pkg::DATA_W; i++) begin : g_bit
    if (i < NCH) begin : g_live
      assign status[i] = irq[i];
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end
endmodule

// File: rtl/uovl_cfg.sv
module uovl_cfg (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_ovl_en,
  output logic ovl_en
);
  always_ff @(posedge clk) begin
    if (rst)         ovl_en <= 1'b1;
    else if (cfg_we) ovl_en <= cfg_ovl_en;
  end

  // R7: the switch loads on a configuration strobe
  a_r7_cfg_load: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (ovl_en == $past(cfg_ovl_en)));
  // R7: without a strobe the switch keeps its value
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(ovl_en));
endmodule

// File: rtl/uovl_rdmux.sv
module uovl_rdmux #(
  parameter int unsigned NCH = 2,
  localparam int unsigned DW = uovl_pkg::DATA_W
) (
  input  logic          rd_hit,
  input  logic          ovl_hit,
  input  logic [NCH-1:0] ch_sel,
  input  logic [DW-1:0] status,
  input  logic [DW*NCH-1:0] uart_rdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] part [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign part[c] = ch_sel[c] ? uart_rdata[c*DW +: DW] : '0;
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      if (ovl_hit) begin
        rdata = status;
      end else begin
        for (int c = 0; c < NCH; c++) rdata = rdata | part[c];
      end
    end
  end
endmodule

// File: rtl/uart_irq_overlay.sv
module uart_irq_overlay #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NCH    = 2,
  localparam int unsigned CH_W    = $clog2(NCH),
  localparam int unsigned WIN_LSB = CH_W + uovl_pkg::OFF_W,
  localparam int unsigned DW      = uovl_pkg::DATA_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      cfg_ovl_en,
  input  logic [ADDR_W-WIN_LSB-1:0] base_sel,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd,
  input  logic                      wr,
  input  logic [NCH-1:0]            irq,
  input  logic [DW*NCH-1:0]         uart_rdata,
  output logic [NCH-1:0]            cs,
  output logic [uovl_pkg::OFF_W-1:0] reg_off,
  output logic [DW-1:0]             rdata
);
  logic                       hit;
  logic [CH_W-1:0]            ch;
  logic [uovl_pkg::OFF_W-1:0] off;
  logic                       ovl_en;
  logic                       ovl_hit;
  logic [DW-1:0]              status;
  logic                       strobe;

  uovl_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .addr(addr), .base_sel(base_sel), .hit(hit), .ch(ch), .off(off));

  uovl_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ovl_en(cfg_ovl_en),
    .ovl_en(ovl_en));

  uovl_status #(.NCH(NCH)) u_stat (.irq(irq), .status(status));

  assign strobe  = rd | wr;
  assign ovl_hit = hit & ovl_en & (off == uovl_pkg::STATUS_OFF);
  assign reg_off = hit ? off : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_cs
    assign cs[c] = hit & strobe & ~ovl_hit & (ch == CH_W'(c));
  end

  uovl_rdmux #(.NCH(NCH)) u_mux (
    .rd_hit(rd & hit), .ovl_hit(ovl_hit), .ch_sel(cs), .status(status),
    .uart_rdata(uart_rdata), .rdata(rdata));

  // R1: at most one channel is selected at a time
  a_r1_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs));
  // R1: a select carries the address offset
  a_r1_offset: assert property (@(posedge clk) disable iff (rst)
    (cs != '0) |-> (reg_off == addr[uovl_pkg::OFF_W-1:0]));
  // R2: outside the window the block is silent
  a_r2_outside: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1:WIN_LSB] != base_sel) |-> (cs == '0 && rdata == '0));
  // R3: overlaid read returns the pending flags
  a_r3_status: assert property (@(posedge clk) disable iff (rst)
    (rd && ovl_en && addr[ADDR_W-1:WIN_LSB] == base_sel &&
     addr[uovl_pkg::OFF_W-1:0] == uovl_pkg::STATUS_OFF)
    |-> (cs == '0 && rdata == DW'(irq)));
  // R5: overlaid writes never reach a UART
  a_r5_write_block: assert property (@(posedge clk) disable iff (rst)
    (wr && ovl_en && addr[uovl_pkg::OFF_W-1:0] == uovl_pkg::STATUS_OFF)
    |-> (cs == '0));
  // R8: selects and data need a strobe
  a_r8_need_strobe: assert property (@(posedge clk) disable iff (rst)
    !(rd || wr) |-> (cs == '0 && rdata == '0));
endmodule

// File: tb/uart_irq_overlay_bench.sv
module uart_irq_overlay_bench;
  localparam int AW = 8;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_ovl_en = 1'b1;
  logic [3:0] base_sel = '0;
  logic [AW-1:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [NC-1:0] irq = '0;
  logic [8*NC-1:0] uart_rdata;
  logic [NC-1:0] cs;
  logic [2:0] reg_off;
  logic [7:0] rdata;
  logic [7:0] stub [NC][8];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_overlay #(.ADDR_W(AW), .NCH(NC)) u_uart_irq_overlay (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ovl_en(cfg_ovl_en),
    .base_sel(base_sel), .addr(addr), .rd(rd), .wr(wr), .irq(irq),
    .uart_rdata(uart_rdata), .cs(cs), .reg_off(reg_off), .rdata(rdata));

  // UART register stubs
  always_comb
    for (int c = 0; c < NC; c++) uart_rdata[c*8 +: 8] = stub[c][reg_off];

  always @(posedge clk)
    if (wr)
      for (int c = 0; c < NC; c++)
        if (cs[c]) stub[c][reg_off] <= wdata;

  function automatic logic [7:0] init_val(int c, int r);
    return 8'(8'h80 + c * 16 + r);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h (addr=%0h base=%0h irq=%0h)",
               req, got, exp, addr, base_sel, irq);
    end
  endtask

  // Arithmetic model of one access at the current inputs
  task automatic check_access(bit en, string tag);
    int a, hitw, ch, off;
    logic [1:0] ecs;
    logic [7:0] erd;
    a = int'(addr);
    hitw = ((a >> 4) == int'(base_sel));
    ch = (a >> 3) & 1;
    off = a & 7;
    ecs = '0;
    erd = '0;
    if (hitw && (rd || wr)) begin
      if (en && off == 7) begin
        if (rd) erd = {6'b0, irq};
      end else begin
        ecs = 2'(1 << ch);
        if (rd) erd = stub[ch][off];
      end
    end
    chk({tag, " cs"}, 32'(cs), 32'(ecs));
    if (ecs != 0) chk({tag, " R1 reg_off"}, 32'(reg_off), 32'(off));
    chk({tag, " rdata"}, 32'(rdata), 32'(erd));
  endtask

  task automatic sweep(bit en);
    int bases[3] = '{0, 3, 15};
    foreach (bases[i]) begin
      for (int a = 0; a < 256; a++) begin
        for (int q = 0; q < 4; q++) begin
          @(negedge clk);
          base_sel = 4'(bases[i]);
          addr = 8'(a);
          irq = 2'(q);
          rd = 1'b1;
          #1;
          check_access(en, "R1/R2/R3/R4/R9 sweep");
        end
      end
    end
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < 8; r++) stub[c][r] = init_val(c, r);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R8 and reset state: no strobe, nothing selected
    base_sel = 4'h3;
    addr = 8'h30;
    #1;
    chk("R8 reset cs", 32'(cs), 0);
    chk("R8 reset rdata", 32'(rdata), 0);

    // R7: overlay on after reset
    @(negedge clk);
    addr = 8'h37; irq = 2'b10; rd = 1'b1;
    #1;
    chk("R7 reset overlay on", 32'(rdata), 32'h02);
    // R4: same cycle change of irq
    irq = 2'b01;
    #1;
    chk("R4 live irq", 32'(rdata), 32'h01);
    irq = 2'b00;
    #1;
    chk("R4 all clear", 32'(rdata), 32'h00);

    // R5: overlaid writes blocked in both windows
    @(negedge clk);
    rd = 1'b0; wr = 1'b1; wdata = 8'h5A; addr = 8'h37;
    #1;
    chk("R5 write A blocked cs", 32'(cs), 0);
    @(negedge clk);
    addr = 8'h3F; wdata = 8'h6B;
    #1;
    chk("R5 write B blocked cs", 32'(cs), 0);
    @(negedge clk);
    wr = 1'b0;

    sweep(1'b1);

    // R7: switch off; effect only from the loading edge
    @(negedge clk);
    cfg_ovl_en = 1'b0; cfg_we = 1'b1;
    base_sel = 4'h3; addr = 8'h37; rd = 1'b1; irq = 2'b11;
    #1;
    chk("R7 before edge", 32'(rdata), 32'h03);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R7 after edge", 32'(rdata), 32'(init_val(0, 7)));
    chk("R5 scratch A untouched", 32'(rdata), 32'(init_val(0, 7)));
    addr = 8'h3F;
    #1;
    chk("R5 scratch B untouched", 32'(rdata), 32'(init_val(1, 7)));
    chk("R6 cs B", 32'(cs), 32'h2);
    chk("R6 reg_off", 32'(reg_off), 7);

    sweep(1'b0);

    // R6: scratch writes land per channel
    @(negedge clk);
    base_sel = 4'h3; addr = 8'h37; wr = 1'b1; wdata = 8'h3C;
    @(negedge clk);
    addr = 8'h3F; wdata = 8'hC3;
    @(negedge clk);
    wr = 1'b0; rd = 1'b1; addr = 8'h37;
    #1;
    chk("R6 scratch A write", 32'(rdata), 32'h3C);
    addr = 8'h3F;
    #1;
    chk("R6 scratch B write", 32'(rdata), 32'hC3);

    // R8: no strobe across the window
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      rd = 1'b0; wr = 1'b0; addr = 8'(a); irq = 2'b11;
      #1;
      chk("R8 idle cs", 32'(cs), 0);
      chk("R8 idle rdata", 32'(rdata), 0);
    end

    // R7: switch back on
    @(negedge clk);
    cfg_ovl_en = 1'b1; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; rd = 1'b1; addr = 8'h3F; irq = 2'b10;
    #1;
    chk("R7 re-enable", 32'(rdata), 32'h02);
    chk("R3 no cs on status", 32'(cs), 0);

    @(negedge clk);
    rd = 1'b0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule